// File: doc/BRIEF.md
# Linearized Track Parameter Fitter

This block turns a road candidate into fitted track quantities with a purely linear calculation. Each candidate brings a road identifier, a layer-combination code, a sub-sector region code and six hit positions. The road identifier gives a coarse position. That position is subtracted from every hit, and the result is clamped to a narrow signed offset, so that the multipliers stay small. The block then computes five outputs. Each output is a stored constant plus a weighted sum of the six offsets. The first three outputs are track parameters and the last two are constraint terms that measure fit quality.

The weights are held in on-chip storage and are selected by layer combination and by region together. This lets the coefficients vary with position inside one azimuthal sector. A single write port loads the coefficient storage before fitting starts. A quality value, the sum of the squares of the two constraint terms, is compared with a programmable threshold to raise a flag. The pipeline accepts one candidate per cycle and has a fixed latency.

Top module: `track_fitter`

## Requirements
- R1: While reset is held and right after it is released, out_valid, out_inval, out_flag and wr_err are low, and in_ready is high when cfg_we is low.
- R2: A candidate is accepted on a rising edge where in_valid and in_ready are both high. Its result is presented with out_valid high after the third rising edge, counting the accepting edge. Results come out in the order of acceptance, and one candidate can be accepted every cycle.
- R3: Each hit i (a 12-bit unsigned value at in_meas[12*i +: 12]) is reduced to the offset d_i = hit − 16·in_road. The offset is saturated to the signed range −64..63.
- R4: Output k (0..4) is (C[k][6] + Σ C[k][i]·d_i) shifted right arithmetically by 4, keeping the low 16 bits as a signed value, and it is placed at out_terms[16*k +: 16]. Outputs 0..2 are track parameters and outputs 3..4 are constraint terms.
- R5: out_quality equals t3² + t4², where t3 and t4 are the two constraint outputs. out_flag is high exactly when out_quality is greater than cfg_thresh (unsigned compare) for a fit in range.
- R6: A coefficient write stores signed 10-bit cfg_data at address cfg_addr = {comb[9:8], region[7:6], output index[5:3], term index[2:0]}. Term index 0..5 weights hit 0..5 and term index 6 is the constant. Later fits that use that set see the new value.
- R7: A candidate with in_comb ≥ cfg_ncomb or in_region ≥ cfg_nreg produces out_inval high together with out_valid. For such a candidate out_terms and out_quality are zero and out_flag is low.
- R8: A write issued while an accepted fit has not yet reached the output register (within two cycles of its acceptance) is ignored. wr_err is high for the one cycle after that write's edge.
- R9: in_ready is low in any cycle where cfg_we is high, so no candidate is accepted alongside a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Candidate present |
| in_ready | output | 1 | Candidate can be accepted |
| in_road | input | 8 | Road identifier (coarse position) |
| in_comb | input | 2 | Layer-combination code |
| in_region | input | 2 | Sub-sector region code |
| in_meas | input | 72 | Six 12-bit hit positions |
| cfg_ncomb | input | 3 | Number of valid combination codes |
| cfg_nreg | input | 3 | Number of valid region codes |
| cfg_thresh | input | 33 | Quality threshold |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 10 | Coefficient address |
| cfg_data | input | 10 | Coefficient value (signed) |
| wr_err | output | 1 | Write rejected because a fit was in flight |
| out_valid | output | 1 | Result present |
| out_inval | output | 1 | Result belongs to an out-of-range candidate |
| out_terms | output | 80 | Five signed 16-bit outputs |
| out_quality | output | 33 | Sum of squared constraint terms |
| out_flag | output | 1 | Quality above threshold |

## Verification
A result is due on the third rising edge after the candidate was driven, counting the accepting edge. The bench records the cycle number at which each candidate is driven and samples outputs on the falling edge. It then compares the cycle at which each result arrives with the driving cycle plus three, and checks the order in which results arrive. wr_err is due one edge after a rejected write, so the bench samples it at the falling edge that follows that write. in_ready responds within the same cycle and is sampled while the write is still held.

// File: rtl/fit_pkg.sv
package fit_pkg;
    localparam int N_MEAS = 6;
    localparam int N_OUT  = 5;
    localparam int N_PAR  = 3;
    localparam int N_TERM = N_MEAS + 1;
    localparam int MW     = 12;
    localparam int RW     = 8;
    localparam int DW     = 7;
    localparam int CW     = 10;
    localparam int CBW    = 2;
    localparam int RBW    = 2;
    localparam int OIW    = 3;
    localparam int MIW    = 3;
    localparam int FRAC   = 4;
    localparam int OUTW   = 16;
    localparam int SEL_W  = CBW + RBW;
    localparam int N_SET  = 1 << SEL_W;
    localparam int AW     = SEL_W + OIW + MIW;
    localparam int SW     = CW + DW + 4;
    localparam int QW     = 2 * OUTW + 1;

    localparam logic signed [MW+1:0] OFS_HI = (MW+2)'((1 << (DW-1)) - 1);
    localparam logic signed [MW+1:0] OFS_LO = (MW+2)'(-(1 << (DW-1)));

    typedef logic signed [DW-1:0]   ofs_t;
    typedef logic signed [CW-1:0]   coef_t;
    typedef logic signed [OUTW-1:0] term_t;

    typedef struct packed {
        logic                    valid;
        logic                    inval;
        logic [SEL_W-1:0]        set;
        ofs_t [N_MEAS-1:0]       ofs;
    } s1_t;

    function automatic ofs_t road_rel(input logic [MW-1:0] m, input logic [RW-1:0] road);
        logic signed [MW+1:0] d;
        d = $signed({2'b00, m}) - $signed({2'b00, road, {(MW-RW){1'b0}}});
        if (d > OFS_HI)      return OFS_HI[DW-1:0];
        else if (d < OFS_LO) return OFS_LO[DW-1:0];
        return d[DW-1:0];
    endfunction
endpackage

// File: rtl/fit_offset.sv
module fit_offset
    import fit_pkg::*;
(
    input  logic [RW-1:0]        road,
    input  logic [N_MEAS*MW-1:0] meas,
    output ofs_t [N_MEAS-1:0]    ofs
);
    for (genvar g = 0; g < N_MEAS; g++) begin : g_ofs
        assign ofs[g] = road_rel(meas[g*MW +: MW], road);
    end
endmodule

// File: rtl/fit_coef_mem.sv
module fit_coef_mem
    import fit_pkg::*;
(
    input  logic                               clk,
    input  logic                               we,
    input  logic [AW-1:0]                      waddr,
    input  logic [CW-1:0]                      wdata,
    input  logic [SEL_W-1:0]                   rset,
    output coef_t [N_OUT-1:0][N_TERM-1:0]      rd
);
    logic [SEL_W-1:0] wset;
    logic [OIW-1:0]   wout;
    logic [MIW-1:0]   wterm;

    assign wset  = waddr[AW-1 -: SEL_W];
    assign wout  = waddr[MIW +: OIW];
    assign wterm = waddr[MIW-1:0];

    for (genvar gk = 0; gk < N_OUT; gk++) begin : g_out
        for (genvar gi = 0; gi < N_TERM; gi++) begin : g_term
            logic [CW-1:0] bank [N_SET];
            always_ff @(posedge clk) begin
                if (we && wout == OIW'(gk) && wterm == MIW'(gi))
                    bank[wset] <= wdata;
            end
            assign rd[gk][gi] = bank[rset];
        end
    end
endmodule

// File: rtl/fit_mac.sv
module fit_mac
    import fit_pkg::*;
(
    input  coef_t [N_TERM-1:0] c,
    input  ofs_t  [N_MEAS-1:0] x,
    output term_t              y
);
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] sh;

    always_comb begin
        acc = SW'($signed(c[N_MEAS]));
        for (int i = 0; i < N_MEAS; i++)
            acc = acc + SW'($signed(c[i])) * SW'($signed(x[i]));
        sh = acc >>> FRAC;
        y  = sh[OUTW-1:0];
    end
endmodule

// File: rtl/track_fitter.sv
module track_fitter
    import fit_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [RW-1:0]         in_road,
    input  logic [CBW-1:0]        in_comb,
    input  logic [RBW-1:0]        in_region,
    input  logic [N_MEAS*MW-1:0]  in_meas,
    input  logic [CBW:0]          cfg_ncomb,
    input  logic [RBW:0]          cfg_nreg,
    input  logic [QW-1:0]         cfg_thresh,
    input  logic                  cfg_we,
    input  logic [AW-1:0]         cfg_addr,
    input  logic [CW-1:0]         cfg_data,
    output logic                  wr_err,
    output logic                  out_valid,
    output logic                  out_inval,
    output logic [N_OUT*OUTW-1:0] out_terms,
    output logic [QW-1:0]         out_quality,
    output logic                  out_flag
);
    logic                           accept;
    logic                           in_range;
    logic                           busy;
    ofs_t  [N_MEAS-1:0]             ofs_in;
    s1_t                            s1;
    coef_t [N_OUT-1:0][N_TERM-1:0]  coefs;
    term_t [N_OUT-1:0]              t_next;
    logic                           v2, inv2;
    term_t [N_OUT-1:0]              t2;
    logic signed [QW-1:0]           q_next;

    assign in_ready = ~cfg_we;
    assign accept   = in_valid & in_ready;
    assign in_range = ({1'b0, in_comb} < cfg_ncomb) && ({1'b0, in_region} < cfg_nreg);
    assign busy     = s1.valid | v2;

    fit_offset u_ofs (
        .road (in_road),
        .meas (in_meas),
        .ofs  (ofs_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= accept;
            s1.inval <= ~in_range;
            s1.set   <= {in_comb, in_region};
            s1.ofs   <= ofs_in;
        end
    end

    fit_coef_mem u_mem (
        .clk   (clk),
        .we    (cfg_we & ~busy),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .rset  (s1.set),
        .rd    (coefs)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_mac
        fit_mac u_mac (
            .c (coefs[k]),
            .x (s1.ofs),
            .y (t_next[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v2   <= 1'b0;
            inv2 <= 1'b0;
            t2   <= '0;
        end else begin
            v2   <= s1.valid;
            inv2 <= s1.inval;
            t2   <= t_next;
        end
    end

    assign q_next = QW'($signed(t2[N_PAR]))   * QW'($signed(t2[N_PAR]))
                  + QW'($signed(t2[N_PAR+1])) * QW'($signed(t2[N_PAR+1]));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_inval   <= 1'b0;
            out_terms   <= '0;
            out_quality <= '0;
            out_flag    <= 1'b0;
            wr_err      <= 1'b0;
        end else begin
            out_valid   <= v2;
            out_inval   <= v2 & inv2;
            out_terms   <= inv2 ? '0 : t2;
            out_quality <= inv2 ? '0 : q_next;
            out_flag    <= v2 & ~inv2 & (q_next > cfg_thresh);
            wr_err      <= cfg_we & busy;
        end
    end
endmodule

// File: rtl/track_fitter_chk.sv
module track_fitter_chk
    import fit_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  cfg_we,
    input logic                  wr_err,
    input logic                  out_valid,
    input logic                  out_inval,
    input logic [N_OUT*OUTW-1:0] out_terms,
    input logic [QW-1:0]         out_quality,
    input logic                  out_flag
);
    logic d1, d2, d3;

    always_ff @(posedge clk) begin
        if (rst) begin
            d1 <= 1'b0;
            d2 <= 1'b0;
            d3 <= 1'b0;
        end else begin
            d1 <= in_valid & in_ready;
            d2 <= d1;
            d3 <= d2;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid == d3);

    assert_inval_zero_R7: assert property (@(posedge clk) disable iff (rst)
        out_inval |-> (out_valid && out_terms == '0 && out_quality == '0 && !out_flag));

    assert_flag_fit_R5: assert property (@(posedge clk) disable iff (rst)
        out_flag |-> (out_valid && !out_inval && out_quality != '0));

    assert_wrerr_src_R8: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(cfg_we));

    assert_no_accept_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_we |-> !(in_valid && in_ready));
endmodule

bind track_fitter track_fitter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .cfg_we      (cfg_we),
    .wr_err      (wr_err),
    .out_valid   (out_valid),
    .out_inval   (out_inval),
    .out_terms   (out_terms),
    .out_quality (out_quality),
    .out_flag    (out_flag)
);

// File: tb/sim_track_fitter.sv
module sim_track_fitter;
    import fit_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int VW = CBW + RBW + RW + N_MEAS*MW;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'd40,  12'd700,  12'd600,  12'd640,  12'd660,  12'd630,  12'd645},
        {2'd1, 2'd2, 8'd100, 12'd1601, 12'd1500, 12'd1700, 12'd1590, 12'd1610, 12'd1600},
        {2'd2, 2'd3, 8'd255, 12'd4070, 12'd4095, 12'd4000, 12'd4090, 12'd4080, 12'd4095},
        {2'd0, 2'd1, 8'd0,   12'd1,    12'd10,   12'd64,   12'd63,   12'd5,    12'd0},
        {2'd3, 2'd0, 8'd5,   12'd80,   12'd81,   12'd82,   12'd83,   12'd84,   12'd85},
        {2'd1, 2'd3, 8'd10,  12'd160,  12'd160,  12'd160,  12'd160,  12'd160,  12'd160},
        {2'd2, 2'd1, 8'd200, 12'd3262, 12'd3137, 12'd3263, 12'd3136, 12'd3201, 12'd3199},
        {2'd0, 2'd3, 8'd1,   12'd0,    12'd79,   12'd20,   12'd40,   12'd17,   12'd15}
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic                  in_ready;
    logic [RW-1:0]         in_road = '0;
    logic [CBW-1:0]        in_comb = '0;
    logic [RBW-1:0]        in_region = '0;
    logic [N_MEAS*MW-1:0]  in_meas = '0;
    logic [CBW:0]          cfg_ncomb = 3'd3;
    logic [RBW:0]          cfg_nreg = 3'd4;
    logic [QW-1:0]         cfg_thresh = 33'd2000000;
    logic                  cfg_we = 1'b0;
    logic [AW-1:0]         cfg_addr = '0;
    logic [CW-1:0]         cfg_data = '0;
    logic                  wr_err, out_valid, out_inval, out_flag;
    logic [N_OUT*OUTW-1:0] out_terms;
    logic [QW-1:0]         out_quality;

    track_fitter u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, nsent = 0, nrcv = 0;
    int cm [N_SET][N_OUT][N_TERM];
    logic                  e_inval [64];
    logic [N_OUT*OUTW-1:0] e_terms [64];
    logic [QW-1:0]         e_q     [64];
    logic                  e_flag  [64];
    int                    e_cyc   [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [N_OUT*OUTW-1:0] act,
                         input logic [N_OUT*OUTW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pat(int s, int k, int i);
        return ((s*37 + k*71 + i*29 + 13) % 401) - 200;
    endfunction

    task automatic model_push(input logic [VW-1:0] v);
        int d [N_MEAS];
        int s, t3, t4, road, set;
        longint q;
        logic [N_OUT*OUTW-1:0] tv;
        logic bad;
        road = int'(v[N_MEAS*MW +: RW]);
        set  = int'(v[VW-1 -: SEL_W]);
        bad  = (int'(v[VW-1 -: CBW]) >= int'(cfg_ncomb)) ||
               (int'(v[VW-CBW-1 -: RBW]) >= int'(cfg_nreg));
        for (int i = 0; i < N_MEAS; i++) begin
            d[i] = int'(v[i*MW +: MW]) - road*16;
            if (d[i] > 63) d[i] = 63;
            if (d[i] < -64) d[i] = -64;
        end
        tv = '0; t3 = 0; t4 = 0;
        for (int k = 0; k < N_OUT; k++) begin
            s = cm[set][k][N_MEAS];
            for (int i = 0; i < N_MEAS; i++) s = s + cm[set][k][i] * d[i];
            s = s >>> FRAC;
            tv[k*OUTW +: OUTW] = s[OUTW-1:0];
            if (k == N_PAR) t3 = s;
            if (k == N_PAR+1) t4 = s;
        end
        q = longint'(t3)*t3 + longint'(t4)*t4;
        e_inval[nsent] = bad;
        e_terms[nsent] = bad ? '0 : tv;
        e_q[nsent]     = bad ? '0 : q[QW-1:0];
        e_flag[nsent]  = !bad && (q > longint'(cfg_thresh));
        e_cyc[nsent]   = cyc;
        nsent++;
    endtask

    task automatic send(input logic [VW-1:0] v);
        model_push(v);
        in_valid  = 1'b1;
        in_comb   = v[VW-1 -: CBW];
        in_region = v[VW-CBW-1 -: RBW];
        in_road   = v[N_MEAS*MW +: RW];
        in_meas   = v[N_MEAS*MW-1:0];
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic cwrite(input int set, input int k, input int i, input int val, input bit keep);
        cfg_we   = 1'b1;
        cfg_addr = {SEL_W'(set), OIW'(k), MIW'(i)};
        cfg_data = CW'(val);
        if (keep) cm[set][k][i] = val;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (nrcv >= nsent) begin
                check(1'b0, "R2 unexpected result", 1, 0);
            end else begin
                check(cyc - e_cyc[nrcv] == 3, "R2 latency", cyc - e_cyc[nrcv], 3);
                check(out_inval == e_inval[nrcv], "R7 inval", out_inval, e_inval[nrcv]);
                check(out_terms == e_terms[nrcv], "R3 R4 R6 terms", out_terms, e_terms[nrcv]);
                check(out_quality == e_q[nrcv], "R5 quality", out_quality, e_q[nrcv]);
                check(out_flag == e_flag[nrcv], "R5 flag", out_flag, e_flag[nrcv]);
            end
            nrcv++;
        end
    end

    task automatic drain();
        repeat (5) @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !out_flag && !wr_err && !out_inval, "R1 reset outputs",
              {out_valid, out_flag, wr_err, out_inval}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !wr_err && in_ready, "R1 after release",
              {out_valid, wr_err, in_ready}, 1);

        for (int s = 0; s < N_SET; s++)
            for (int k = 0; k < N_OUT; k++)
                for (int i = 0; i < N_TERM; i++)
                    cwrite(s, k, i, pat(s, k, i), 1'b1);
        check(!wr_err, "R8 idle writes", wr_err, 0);

        // back-to-back stream of the table
        for (int n = 0; n < NV; n++) begin
            model_push(VEC[n]);
            in_valid  = 1'b1;
            in_comb   = VEC[n][VW-1 -: CBW];
            in_region = VEC[n][VW-CBW-1 -: RBW];
            in_road   = VEC[n][N_MEAS*MW +: RW];
            in_meas   = VEC[n][N_MEAS*MW-1:0];
            @(negedge clk);
        end
        in_valid = 1'b0;
        drain();

        // R7 region limit
        cfg_nreg = 3'd2;
        send(VEC[1]);
        send(VEC[3]);
        drain();
        cfg_nreg = 3'd4;

        // R5 threshold extremes
        cfg_thresh = '0;
        send(VEC[5]);
        drain();
        cfg_thresh = '1;
        send(VEC[0]);
        drain();
        cfg_thresh = 33'd2000000;

        // R8 write during fit, R9 ready low during write
        send(VEC[0]);
        cfg_we   = 1'b1;
        cfg_addr = {SEL_W'(0), OIW'(0), MIW'(6)};
        cfg_data = CW'(100);
        #1;
        check(!in_ready, "R9 ready during write", in_ready, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        check(wr_err, "R8 rejected write flag", wr_err, 1);
        @(negedge clk);
        check(!wr_err, "R8 flag one cycle", wr_err, 0);
        drain();
        send(VEC[0]);
        drain();

        // R6 accepted rewrite of a constant and a weight
        cwrite(0, 0, 6, 100, 1'b1);
        check(!wr_err, "R8 idle write no flag", wr_err, 0);
        cwrite(0, 4, 2, -150, 1'b1);
        send(VEC[0]);
        drain();

        check(nrcv == nsent, "R2 result count", nrcv, nsent);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule